// File: doc/BRIEF.md
# Suspend and Wake Controller

This controller sequences a small microcontroller into and out of its low-power state. Firmware starts suspend with one I/O write to the status and control register. The write must carry the suspend flag (bit 3) and, in the normal case, the run flag (bit 0), which gives the value 0x09. While suspended, the controller turns off the oscillator, the PLL, the free-running timer and the watchdog timer. Only the wake logic keeps running.

A wake event is either a GPIO interrupt request whose enable is set, or non-idle activity on the upstream USB port or on any downstream USB port. A wake event starts a two-stage resume:

1. The oscillator and PLL are turned back on at once. The controller then waits for the oscillator-stable input.
2. After that input rises, the core is held idle for a settle period of a parameterised number of cycles (1 ms at the system clock rate). Only then are the timers enabled and the core released.

An interrupt hold output keeps the core from accepting an interrupt after resume. It stays set until the instruction that follows the suspend write has completed. The oscillator itself is not modelled; it appears only as the stable input.

Top module: `susp_wake_ctrl`

## Requirements
- R1: After reset, and at any time reset is asserted, the controller is in run mode. In run mode `osc_en`, `pll_en`, `frt_en`, `wdt_en` and `core_ready` are 1 and `irq_hold` is 0.
- R2: In run mode, a write to address 0xFF whose data has bit 3 set enters suspend on the next cycle. In suspend all four enables and `core_ready` are 0 and `irq_hold` is 1. A write to any other address, or a write with bit 3 clear, leaves run mode unchanged.
- R3: In suspend, a GPIO request whose matching enable bit is 0 does not end suspend, however long it stays pending.
- R4: In suspend, a GPIO request with its enable bit set ends suspend on the next cycle. At that point `osc_en` and `pll_en` become 1, while `frt_en`, `wdt_en` and `core_ready` stay 0.
- R5: In suspend, `usb_up_active` or any bit of `usb_dn_active` ends suspend in the same way as R4.
- R6: If the write that entered suspend had bit 0 (run) clear, no wake event ends suspend. Only reset leaves that state.
- R7: After wake, `core_ready` stays 0 for as long as `osc_stable` is 0.
- R8: `core_ready`, `frt_en` and `wdt_en` rise exactly SETTLE_CYC+1 clock edges after the edge that first samples `osc_stable` high, counting that edge. This holds when `osc_stable` stays high throughout.
- R9: If `osc_stable` falls during the settle period, the controller returns to waiting for stability on the next cycle. The next rise of `osc_stable` restarts the settle count from zero.
- R10: `irq_hold` stays 1 after resume until the first `instr_done` pulse sampled while `core_ready` is 1, and falls on the next cycle. `instr_done` pulses before the core is ready have no effect. When a suspend write and `instr_done` arrive in the same cycle, the hold is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_wr_en | input | 1 | I/O write strobe |
| io_addr | input | 8 | I/O write address |
| io_wdata | input | 8 | I/O write data |
| gpio_irq_req | input | N_GPIO | Pending GPIO interrupt requests |
| gpio_irq_en | input | N_GPIO | Per-pin GPIO interrupt enables |
| usb_up_active | input | 1 | Upstream USB port not idle |
| usb_dn_active | input | N_DN | Downstream USB ports not idle |
| osc_stable | input | 1 | Oscillator reports stable |
| instr_done | input | 1 | Core finished an instruction |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| frt_en | output | 1 | Free-running timer enable |
| wdt_en | output | 1 | Watchdog timer enable |
| core_ready | output | 1 | Core released from idle |
| irq_hold | output | 1 | Interrupt acceptance blocked |

## Verification
The bench holds a GPIO request pending against a cleared enable bit. A controller that ignored the mask would start the oscillator there. It also enters suspend with the run flag clear and then drives every wake source; a design that ignored the flag would resume.

The settle window is cut short by dropping `osc_stable` after three cycles. A counter that was not restarted would release the core several cycles early, and the exact release cycle is checked against SETTLE_CYC. The bench also pulses `instr_done` before the core is ready, and again in the same cycle as a suspend write. A hold that cleared too early would then let an interrupt in ahead of the instruction that follows the suspend write.

// File: rtl/susp_pkg.sv
package susp_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_SUSP   = 2'd1,
    ST_OSCW   = 2'd2,
    ST_SETTLE = 2'd3
  } pwr_state_e;
endpackage

// File: rtl/susp_reg_decode.sv
module susp_reg_decode #(
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  SC_ADDR  = 8'hFF,
  parameter int          SUSP_BIT = 3,
  parameter int          RUN_BIT  = 0
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              enter_req,
  output logic              run_req
);
  localparam logic [ADDR_W-1:0] MATCH = ADDR_W'(SC_ADDR);

  logic hit;

  always_comb begin
    hit       = wr_en && (addr == MATCH);
    enter_req = hit && wdata[SUSP_BIT];
    run_req   = wdata[RUN_BIT];
  end
endmodule

// File: rtl/susp_wake_detect.sv
module susp_wake_detect #(
  parameter int N_GPIO = 8,
  parameter int N_DN   = 4
) (
  input  logic [N_GPIO-1:0] gpio_req,
  input  logic [N_GPIO-1:0] gpio_en,
  input  logic              up_active,
  input  logic [N_DN-1:0]   dn_active,
  output logic              wake
);
  logic [N_GPIO-1:0] gpio_live;

  genvar g;
  generate
    for (g = 0; g < N_GPIO; g++) begin : g_mask
      assign gpio_live[g] = gpio_req[g] & gpio_en[g];
    end
  endgenerate

  always_comb begin
    wake = (|gpio_live) | up_active | (|dn_active);
  end
endmodule

// File: rtl/susp_seq.sv
module susp_seq
  import susp_pkg::*;
#(
  parameter int SETTLE_CYC = 48000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter_req,
  input  logic       run_req,
  input  logic       wake,
  input  logic       osc_stable,
  output pwr_state_e state_o,
  output logic       enter_fire_o
);
  localparam int              CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

  pwr_state_e       st_q, st_d;
  logic             run_q, run_d, run_ld;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en, cnt_clr;

  always_comb begin
    st_d    = st_q;
    run_ld  = 1'b0;
    cnt_en  = 1'b0;
    cnt_clr = 1'b0;
    case (st_q)
      ST_RUN: begin
        if (enter_req) begin
          st_d   = ST_SUSP;
          run_ld = 1'b1;
        end
      end
      ST_SUSP: begin
        if (wake && run_q) st_d = ST_OSCW;
      end
      ST_OSCW: begin
        if (osc_stable) begin
          st_d    = ST_SETTLE;
          cnt_clr = 1'b1;
        end
      end
      ST_SETTLE: begin
        if (!osc_stable)          st_d   = ST_OSCW;
        else if (cnt_q == LAST)   st_d   = ST_RUN;
        else                      cnt_en = 1'b1;
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_comb begin
    run_d = run_ld ? run_req : run_q;
    if (cnt_clr)     cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + CNT_W'(1);
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_RUN;
      run_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign state_o      = st_q;
  assign enter_fire_o = (st_q == ST_RUN) && enter_req;
endmodule

// File: rtl/susp_out.sv
module susp_out
  import susp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  pwr_state_e state,
  input  logic       enter_fire,
  input  logic       instr_done,
  output logic       osc_en,
  output logic       pll_en,
  output logic       frt_en,
  output logic       wdt_en,
  output logic       core_ready,
  output logic       irq_hold
);
  logic hold_q, hold_d, running;

  always_comb begin
    running    = (state == ST_RUN);
    osc_en     = (state != ST_SUSP);
    pll_en     = (state != ST_SUSP);
    frt_en     = running;
    wdt_en     = running;
    core_ready = running;
    if (enter_fire)                      hold_d = 1'b1;
    else if (running && instr_done)      hold_d = 1'b0;
    else                                 hold_d = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  assign irq_hold = hold_q;
endmodule

// File: rtl/susp_wake_ctrl.sv
module susp_wake_ctrl
  import susp_pkg::*;
#(
  parameter int         N_GPIO     = 8,
  parameter int         N_DN       = 4,
  parameter int         SETTLE_CYC = 48000,
  parameter logic [7:0] SC_ADDR    = 8'hFF,
  parameter int         SUSP_BIT   = 3,
  parameter int         RUN_BIT    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              io_wr_en,
  input  logic [7:0]        io_addr,
  input  logic [7:0]        io_wdata,
  input  logic [N_GPIO-1:0] gpio_irq_req,
  input  logic [N_GPIO-1:0] gpio_irq_en,
  input  logic              usb_up_active,
  input  logic [N_DN-1:0]   usb_dn_active,
  input  logic              osc_stable,
  input  logic              instr_done,
  output logic              osc_en,
  output logic              pll_en,
  output logic              frt_en,
  output logic              wdt_en,
  output logic              core_ready,
  output logic              irq_hold
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  logic       enter_req, run_req, wake, enter_fire;
  pwr_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  susp_reg_decode #(
    .ADDR_W(8), .DATA_W(8), .SC_ADDR(SC_ADDR),
    .SUSP_BIT(SUSP_BIT), .RUN_BIT(RUN_BIT)
  ) u_dec (
    .wr_en(io_wr_en), .addr(io_addr), .wdata(io_wdata),
    .enter_req(enter_req), .run_req(run_req)
  );

  susp_wake_detect #(.N_GPIO(N_GPIO), .N_DN(N_DN)) u_wake (
    .gpio_req(gpio_irq_req), .gpio_en(gpio_irq_en),
    .up_active(usb_up_active), .dn_active(usb_dn_active),
    .wake(wake)
  );

  susp_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .enter_req(enter_req), .run_req(run_req), .wake(wake),
    .osc_stable(osc_stable),
    .state_o(state), .enter_fire_o(enter_fire)
  );

  susp_out u_out (
    .clk(clk), .rst_n(rst_sync_n),
    .state(state), .enter_fire(enter_fire), .instr_done(instr_done),
    .osc_en(osc_en), .pll_en(pll_en), .frt_en(frt_en), .wdt_en(wdt_en),
    .core_ready(core_ready), .irq_hold(irq_hold)
  );
endmodule

// File: rtl/susp_wake_chk.sv
module susp_wake_chk #(
  parameter int         N_GPIO   = 8,
  parameter int         N_DN     = 4,
  parameter logic [7:0] SC_ADDR  = 8'hFF,
  parameter int         SUSP_BIT = 3
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              io_wr_en,
  input logic [7:0]        io_addr,
  input logic [7:0]        io_wdata,
  input logic [N_GPIO-1:0] gpio_irq_req,
  input logic [N_GPIO-1:0] gpio_irq_en,
  input logic              usb_up_active,
  input logic [N_DN-1:0]   usb_dn_active,
  input logic              osc_stable,
  input logic              instr_done,
  input logic              osc_en,
  input logic              core_ready,
  input logic              irq_hold
);
  logic wr_susp, any_wake;
  assign wr_susp  = io_wr_en && (io_addr == SC_ADDR) && io_wdata[SUSP_BIT];
  assign any_wake = (|(gpio_irq_req & gpio_irq_en)) || usb_up_active || (|usb_dn_active);

  // R2: suspend write from run mode gates clocks and raises the hold
  p_enter_r2: assert property (@(posedge clk) disable iff (!rst_ok)
    (core_ready && wr_susp) |=> (!osc_en && !core_ready && irq_hold));

  // R3: no enabled wake source keeps the part suspended
  p_masked_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    (!osc_en && !any_wake) |=> !osc_en);

  // R7: core stays idle while the oscillator is unstable
  p_unstable_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    (osc_en && !core_ready && !osc_stable) |=> !core_ready);

  // R8: release only follows a stable oscillator
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(core_ready) |-> $past(osc_stable));

  // R10: hold persists without a completion pulse
  p_hold_keep_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    (irq_hold && !instr_done) |=> irq_hold);

  // R10: completion while ready drops the hold
  p_hold_drop_r10: assert property (@(posedge clk) disable iff (!rst_ok)
    (irq_hold && instr_done && core_ready && !wr_susp) |=> !irq_hold);
endmodule

bind susp_wake_ctrl susp_wake_chk #(
  .N_GPIO(N_GPIO), .N_DN(N_DN), .SC_ADDR(SC_ADDR), .SUSP_BIT(SUSP_BIT)
) u_chk (
  .clk(clk), .rst_ok(rst_sync_n),
  .io_wr_en(io_wr_en), .io_addr(io_addr), .io_wdata(io_wdata),
  .gpio_irq_req(gpio_irq_req), .gpio_irq_en(gpio_irq_en),
  .usb_up_active(usb_up_active), .usb_dn_active(usb_dn_active),
  .osc_stable(osc_stable), .instr_done(instr_done),
  .osc_en(osc_en), .core_ready(core_ready), .irq_hold(irq_hold)
);

// File: tb/tb_susp_wake_ctrl.sv
module tb_susp_wake_ctrl;
  localparam int N_GPIO = 4;
  localparam int N_DN   = 2;
  localparam int S      = 8;

  // output vector order: osc_en pll_en frt_en wdt_en core_ready irq_hold
  localparam logic [5:0] RUN0 = 6'b111110;
  localparam logic [5:0] RUNH = 6'b111111;
  localparam logic [5:0] SUSP = 6'b000001;
  localparam logic [5:0] OSCW = 6'b110001;

  logic clk, rst_n;
  logic io_wr_en;
  logic [7:0] io_addr, io_wdata;
  logic [N_GPIO-1:0] gpio_irq_req, gpio_irq_en;
  logic usb_up_active;
  logic [N_DN-1:0] usb_dn_active;
  logic osc_stable, instr_done;
  logic osc_en, pll_en, frt_en, wdt_en, core_ready, irq_hold;

  susp_wake_ctrl #(.N_GPIO(N_GPIO), .N_DN(N_DN), .SETTLE_CYC(S)) dut (
    .clk(clk), .rst_n(rst_n),
    .io_wr_en(io_wr_en), .io_addr(io_addr), .io_wdata(io_wdata),
    .gpio_irq_req(gpio_irq_req), .gpio_irq_en(gpio_irq_en),
    .usb_up_active(usb_up_active), .usb_dn_active(usb_dn_active),
    .osc_stable(osc_stable), .instr_done(instr_done),
    .osc_en(osc_en), .pll_en(pll_en), .frt_en(frt_en), .wdt_en(wdt_en),
    .core_ready(core_ready), .irq_hold(irq_hold)
  );

  typedef struct {
    int         cyc;
    logic [5:0] val;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 0;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [5:0] outs();
    return {osc_en, pll_en, frt_en, wdt_en, core_ready, irq_hold};
  endfunction

  // monitor: pop every expectation due this cycle and compare
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (e.cyc != cyc || outs() !== e.val) begin
        n_bad++;
        $display("FAIL %s: cycle %0d got %b expected %b", e.tag, cyc, outs(), e.val);
      end
    end
  end

  task automatic expect_at(input int k, input logic [5:0] v, input string tag);
    q.push_back('{cyc + k, v, tag});
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic [5:0] v, input string tag);
    io_wr_en = 1'b1; io_addr = a; io_wdata = d;
    expect_at(1, v, tag);
    step(1);
    io_wr_en = 1'b0; io_addr = '0; io_wdata = '0;
  endtask

  task automatic settle_and_release(input string tag);
    osc_stable = 1'b1;
    for (int k = 1; k <= S; k++) expect_at(k, OSCW, tag);
    expect_at(S + 1, RUNH, tag);
    step(S + 1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    io_wr_en = 1'b0; io_addr = '0; io_wdata = '0;
    gpio_irq_req = '0; gpio_irq_en = '0;
    usb_up_active = 1'b0; usb_dn_active = '0;
    osc_stable = 1'b1; instr_done = 1'b0;
    step(2);
    expect_at(1, RUN0, "R1 in reset");
    step(1);
    rst_n = 1'b1;
    expect_at(1, RUN0, "R1 after release");
    step(3);

    // R2 negative and positive cases
    wr(8'hFE, 8'h09, RUN0, "R2 other address ignored");
    step(1);
    wr(8'hFF, 8'h01, RUN0, "R2 suspend bit clear ignored");
    step(1);
    wr(8'hFF, 8'h09, SUSP, "R2 enter suspend");
    osc_stable = 1'b0;

    // R3 masked GPIO request
    gpio_irq_req = 4'b0100; gpio_irq_en = 4'b1011;
    for (int k = 1; k <= 3; k++) expect_at(k, SUSP, "R3 masked request");
    step(3);
    gpio_irq_req = '0;

    // R4 enabled GPIO wake
    gpio_irq_req = 4'b0001; gpio_irq_en = 4'b0001;
    expect_at(1, OSCW, "R4 enabled gpio wake");
    step(1);
    gpio_irq_req = '0;
    instr_done = 1'b1;
    expect_at(1, OSCW, "R10 instr_done before ready ignored");
    step(1);
    instr_done = 1'b0;
    for (int k = 1; k <= 3; k++) expect_at(k, OSCW, "R7 wait for stable");
    step(3);
    settle_and_release("R8 settle length");

    expect_at(1, RUNH, "R10 hold persists");
    step(1);
    instr_done = 1'b1;
    expect_at(1, RUN0, "R10 hold released");
    step(1);
    instr_done = 1'b0;

    // R10 suspend write and completion in the same cycle
    instr_done = 1'b1;
    wr(8'hFF, 8'h09, SUSP, "R10 set wins over completion");
    instr_done = 1'b0;
    osc_stable = 1'b0;

    // R5 downstream wake, R9 stability drop
    usb_dn_active = 2'b10;
    expect_at(1, OSCW, "R5 downstream wake");
    step(1);
    usb_dn_active = '0;
    osc_stable = 1'b1;
    for (int k = 1; k <= 3; k++) expect_at(k, OSCW, "R9 partial settle");
    step(3);
    osc_stable = 1'b0;
    for (int k = 1; k <= 2; k++) expect_at(k, OSCW, "R9 back to wait");
    step(2);
    settle_and_release("R9 count restarted");
    instr_done = 1'b1;
    expect_at(1, RUN0, "R10 hold released again");
    step(1);
    instr_done = 1'b0;

    // R6 suspend without run flag
    wr(8'hFF, 8'h08, SUSP, "R6 enter without run");
    osc_stable = 1'b0;
    usb_up_active = 1'b1; usb_dn_active = 2'b01;
    gpio_irq_req = 4'b0010; gpio_irq_en = 4'b0010;
    for (int k = 1; k <= 4; k++) expect_at(k, SUSP, "R6 no resume");
    step(4);
    usb_up_active = 1'b0; usb_dn_active = '0; gpio_irq_req = '0;

    rst_n = 1'b0;
    expect_at(1, RUN0, "R1 reset leaves suspend");
    step(2);
    rst_n = 1'b1;
    osc_stable = 1'b1;
    step(3);

    // R5 upstream wake
    wr(8'hFF, 8'h09, SUSP, "R2 enter suspend again");
    osc_stable = 1'b0;
    usb_up_active = 1'b1;
    expect_at(1, OSCW, "R5 upstream wake");
    step(1);
    usb_up_active = 1'b0;
    settle_and_release("R8 settle after upstream wake");

    step(3);
    if (q.size() > 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: %0d expectations left, expected 0", q.size());
    end
    finish_run();
  end
endmodule